// File: doc/BRIEF.md
# Secure Mode Tracker and Region Access Guard

This block keeps the security mode of the running process and judges every memory access of that process against four protected address windows. A process starts in the standard (untrusted) mode. To enter secure processing it issues a start event. The block then waits in a hashing state until an external engine reports that the program hash is done. The start event also picks the flavour of secure processing: tamper-evident (integrity only) or private (integrity and privacy). From a secure mode the process may suspend into a reduced-privilege mode for untrusted helper code. It may come back only through a resume event whose target address equals the one registered entry point. An exit event returns the process to the standard mode from any state.

Each access is classified by address as static-verified, static-encrypted, dynamic-verified, dynamic-encrypted or unprotected. The verdict (allow or fault) and the two attributes (needs integrity verification, needs encryption) are produced combinationally in the same cycle as the access. The memory protection engines downstream use the attributes to pick their treatment of the access. Mode changes take effect on the clock edge after the event.

States: `MD_STD` (code 0), `MD_HASH` (1), `MD_TEV` (2), `MD_PRIV` (3), `MD_SUSP` (4). Transitions: STD→HASH on start; HASH→TEV or HASH→PRIV on hash done, chosen by the flavour latched at start; TEV/PRIV→SUSP on suspend; SUSP→TEV/PRIV on a resume that targets the entry point; any non-standard state→STD on exit.

Top module: `secmode_guard`

## Requirements
- R1: After reset the `mode` output is 0 (standard). The mode codes are 0 standard, 1 hashing, 2 tamper-evident, 3 private and 4 suspended.
- R2: A start event in mode 0 moves to mode 1 on the next clock. Mode 1 holds until `hash_done`. It then moves to mode 3 if `start_private` was 1 with the start event, and to mode 2 otherwise.
- R3: A suspend event in mode 2 or 3 moves to mode 4 on the next clock. A resume event in mode 4 whose `resume_pc` equals `entry_pc` returns to the secure mode that was held before the suspension.
- R4: A resume event with `resume_pc` different from `entry_pc`, or a resume event outside mode 4, drives `resume_fault` high in the same cycle and leaves the mode unchanged.
- R5: An exit event in any mode other than 0 moves to mode 0 on the next clock. It wins over a suspend, resume or hash-done event in the same cycle.
- R6: Window i covers `base_i <= addr < bound_i`. Bases and bounds are packed at bits [i*AW +: AW] of `region_base` and `region_bound`. Window index gives the class: 0 static verified, 1 static encrypted, 2 dynamic verified, 3 dynamic encrypted. Where windows overlap, the lowest index wins. An address in no window is unprotected.
- R7: An unprotected access is allowed in every mode, with both attributes low.
- R8: In modes 0, 1 and 4, any access to a protected window faults.
- R9: A write to a static window (class 0 or 1) faults in every mode.
- R10: In mode 2, accesses to encrypted windows (class 1 or 3) fault. Permitted accesses to verified windows are allowed with `acc_need_verify` high and `acc_need_encrypt` low.
- R11: In mode 3, every protected access not barred by R9 is allowed with `acc_need_verify` high. `acc_need_encrypt` is high only for classes 1 and 3.
- R12: Access outputs follow the access inputs in the same cycle. With `acc_valid` low, allow, fault and both attributes are 0. With `acc_valid` high, exactly one of allow and fault is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Start-secure event |
| start_private | input | 1 | With start: 1 selects private, 0 tamper-evident |
| hash_done | input | 1 | Program hash computation finished |
| suspend_req | input | 1 | Suspend event |
| resume_req | input | 1 | Resume event |
| resume_pc | input | AW | Target address of the resume |
| entry_pc | input | AW | Registered resume entry address |
| exit_req | input | 1 | Exit event |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | AW | Access address |
| acc_write | input | 1 | 1 write, 0 read |
| region_base | input | 4*AW | Packed window base addresses |
| region_bound | input | 4*AW | Packed window bounds (exclusive) |
| mode | output | 3 | Current mode code |
| resume_fault | output | 1 | Rejected resume event |
| acc_allow | output | 1 | Access permitted |
| acc_fault | output | 1 | Access denied |
| acc_need_verify | output | 1 | Access needs integrity verification |
| acc_need_encrypt | output | 1 | Access needs encryption |

## Verification
The hardest states to reach are a resume back into the private flavour and an exit that collides with a suspend. The first needs a full start, hash and suspend sequence with the private flag set. The second needs two events raised in the same cycle. The stimulus walks a complete tamper-evident session and then a complete private session, placing a rejected resume, a resume outside suspension and a combined exit-plus-suspend event along the way. Window overlap is produced by moving one bound mid-run so that a static window covers part of a dynamic one.

// File: rtl/secg_pkg.sv
package secg_pkg;

    typedef enum logic [2:0] {
        MD_STD  = 3'd0,
        MD_HASH = 3'd1,
        MD_TEV  = 3'd2,
        MD_PRIV = 3'd3,
        MD_SUSP = 3'd4
    } sec_mode_e;

    typedef enum logic [2:0] {
        RC_STAT_VER = 3'd0,
        RC_STAT_ENC = 3'd1,
        RC_DYN_VER  = 3'd2,
        RC_DYN_ENC  = 3'd3,
        RC_OPEN     = 3'd4
    } region_cls_e;

    localparam int unsigned NUM_WIN = 4;

    function automatic logic cls_is_static(region_cls_e c);
        return (c == RC_STAT_VER) || (c == RC_STAT_ENC);
    endfunction

    function automatic logic cls_is_enc(region_cls_e c);
        return (c == RC_STAT_ENC) || (c == RC_DYN_ENC);
    endfunction

    function automatic logic cls_is_prot(region_cls_e c);
        return c != RC_OPEN;
    endfunction

endpackage

// File: rtl/secg_mode_fsm.sv
module secg_mode_fsm
    import secg_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          start_private,
    input  logic          hash_done,
    input  logic          suspend_req,
    input  logic          resume_req,
    input  logic [AW-1:0] resume_pc,
    input  logic [AW-1:0] entry_pc,
    input  logic          exit_req,
    output sec_mode_e     mode_o,
    output logic          resume_fault
);

    sec_mode_e mode_q, mode_d;
    logic      sess_priv_q, sess_priv_d;
    logic      pc_match;
    sec_mode_e secure_ret;

    assign pc_match   = (resume_pc == entry_pc);
    assign secure_ret = sess_priv_q ? MD_PRIV : MD_TEV;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= MD_STD;
            sess_priv_q <= 1'b0;
        end else begin
            mode_q      <= mode_d;
            sess_priv_q <= sess_priv_d;
        end
    end

    // next-state logic
    always_comb begin
        mode_d      = mode_q;
        sess_priv_d = sess_priv_q;
        unique case (mode_q)
            MD_STD: begin
                if (start_req) begin
                    mode_d      = MD_HASH;
                    sess_priv_d = start_private;
                end
            end
            MD_HASH: begin
                if (exit_req)       mode_d = MD_STD;
                else if (hash_done) mode_d = secure_ret;
            end
            MD_TEV, MD_PRIV: begin
                if (exit_req)         mode_d = MD_STD;
                else if (suspend_req) mode_d = MD_SUSP;
            end
            MD_SUSP: begin
                if (exit_req)                    mode_d = MD_STD;
                else if (resume_req && pc_match) mode_d = secure_ret;
            end
            default: mode_d = MD_STD;
        endcase
    end

    // outputs
    always_comb begin
        mode_o       = mode_q;
        resume_fault = 1'b0;
        unique case (mode_q)
            MD_SUSP: resume_fault = resume_req && !pc_match;
            MD_STD, MD_HASH, MD_TEV, MD_PRIV: resume_fault = resume_req;
            default: resume_fault = resume_req;
        endcase
    end

    a_r1_reset_std: assert property (@(posedge clk)
        $rose(rst_n) |-> mode_q == MD_STD);

    a_r2_hash_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_HASH && !hash_done && !exit_req) |=> mode_q == MD_HASH);

    a_r3_susp_only_from_secure: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_STD || mode_q == MD_HASH) |=> mode_q != MD_SUSP);

    a_r4_bad_resume_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_SUSP && resume_fault && !exit_req) |=> mode_q == MD_SUSP);

    a_r5_exit_to_std: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_req && mode_q != MD_STD) |=> mode_q == MD_STD);

endmodule

// File: rtl/secg_region_match.sv
module secg_region_match
    import secg_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned NWIN = NUM_WIN
) (
    input  logic [AW-1:0]      addr,
    input  logic [NWIN*AW-1:0] base_flat,
    input  logic [NWIN*AW-1:0] bound_flat,
    output region_cls_e        cls
);

    localparam int unsigned CW = $bits(region_cls_e);

    logic [NWIN-1:0] hit;

    for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
        logic [AW-1:0] lo, hi;
        assign lo      = base_flat[gi*AW +: AW];
        assign hi      = bound_flat[gi*AW +: AW];
        assign hit[gi] = (addr >= lo) && (addr < hi);
    end

    // lowest index has priority
    always_comb begin
        cls = RC_OPEN;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit[i]) cls = region_cls_e'(CW'(i));
        end
    end

endmodule

// File: rtl/secg_access_policy.sv
module secg_access_policy
    import secg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  sec_mode_e   mode,
    input  region_cls_e cls,
    input  logic        acc_valid,
    input  logic        acc_write,
    output logic        acc_allow,
    output logic        acc_fault,
    output logic        acc_need_verify,
    output logic        acc_need_encrypt
);

    logic permit;
    logic prot, stat, enc;

    assign prot = cls_is_prot(cls);
    assign stat = cls_is_static(cls);
    assign enc  = cls_is_enc(cls);

    always_comb begin
        permit = 1'b0;
        unique case (mode)
            MD_STD, MD_HASH, MD_SUSP: permit = !prot;
            MD_TEV:  permit = !prot || (!enc && !(stat && acc_write));
            MD_PRIV: permit = !prot || !(stat && acc_write);
            default: permit = !prot;
        endcase
    end

    always_comb begin
        acc_allow        = acc_valid && permit;
        acc_fault        = acc_valid && !permit;
        acc_need_verify  = acc_valid && permit && prot;
        acc_need_encrypt = acc_valid && permit && enc;
    end

    a_r8_prot_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && prot && (mode == MD_STD || mode == MD_HASH || mode == MD_SUSP))
        |-> acc_fault);

    a_r9_static_write: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && stat) |-> (acc_fault && !acc_allow));

    a_r11_enc_needs_verify: assert property (@(posedge clk) disable iff (!rst_n)
        acc_need_encrypt |-> acc_need_verify);

    a_r12_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $countones({acc_allow, acc_fault}) == 1);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !(acc_allow || acc_fault || acc_need_verify || acc_need_encrypt));

endmodule

// File: rtl/secmode_guard.sv
module secmode_guard
    import secg_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_req,
    input  logic                  start_private,
    input  logic                  hash_done,
    input  logic                  suspend_req,
    input  logic                  resume_req,
    input  logic [AW-1:0]         resume_pc,
    input  logic [AW-1:0]         entry_pc,
    input  logic                  exit_req,
    input  logic                  acc_valid,
    input  logic [AW-1:0]         acc_addr,
    input  logic                  acc_write,
    input  logic [NUM_WIN*AW-1:0] region_base,
    input  logic [NUM_WIN*AW-1:0] region_bound,
    output logic [2:0]            mode,
    output logic                  resume_fault,
    output logic                  acc_allow,
    output logic                  acc_fault,
    output logic                  acc_need_verify,
    output logic                  acc_need_encrypt
);

    sec_mode_e   cur_mode;
    region_cls_e cls;

    secg_mode_fsm #(.AW(AW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .start_private(start_private),
        .hash_done    (hash_done),
        .suspend_req  (suspend_req),
        .resume_req   (resume_req),
        .resume_pc    (resume_pc),
        .entry_pc     (entry_pc),
        .exit_req     (exit_req),
        .mode_o       (cur_mode),
        .resume_fault (resume_fault)
    );

    secg_region_match #(.AW(AW), .NWIN(NUM_WIN)) u_match (
        .addr      (acc_addr),
        .base_flat (region_base),
        .bound_flat(region_bound),
        .cls       (cls)
    );

    secg_access_policy u_policy (
        .clk             (clk),
        .rst_n           (rst_n),
        .mode            (cur_mode),
        .cls             (cls),
        .acc_valid       (acc_valid),
        .acc_write       (acc_write),
        .acc_allow       (acc_allow),
        .acc_fault       (acc_fault),
        .acc_need_verify (acc_need_verify),
        .acc_need_encrypt(acc_need_encrypt)
    );

    assign mode = cur_mode;

    a_r7_open_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cls == RC_OPEN) |-> (acc_allow && !acc_need_verify && !acc_need_encrypt));

endmodule

// File: tb/secmode_guard_test.sv
module secmode_guard_test;
    localparam int AW = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_req = 0, start_private = 0, hash_done = 0, suspend_req = 0;
    logic resume_req = 0, exit_req = 0, acc_valid = 0, acc_write = 0;
    logic [AW-1:0] resume_pc = '0, entry_pc = 32'h100, acc_addr = '0;
    logic [4*AW-1:0] region_base, region_bound;
    logic [2:0] mode;
    logic resume_fault, acc_allow, acc_fault, acc_need_verify, acc_need_encrypt;

    always #4 clk = ~clk;

    secmode_guard #(.AW(AW)) uut (.*);

    typedef struct {
        string      tag;
        logic [2:0] m;
        logic [4:0] o; // allow, fault, verify, encrypt, resume_fault
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // staged stimulus
    logic s_start = 0, s_priv = 0, s_hdone = 0, s_susp = 0, s_res = 0, s_exit = 0;
    logic [AW-1:0] s_rpc = '0;
    logic s_val = 0, s_wr = 0;
    logic [AW-1:0] s_addr = '0;
    logic [AW-1:0] s_bound1 = 32'h3000;

    initial begin
        region_base  = {32'h4000, 32'h3000, 32'h2000, 32'h1000};
        region_bound = {32'h5000, 32'h4000, 32'h3000, 32'h2000};
    end

    task automatic acc(input logic v, input logic w, input logic [AW-1:0] a);
        s_val = v; s_wr = w; s_addr = a;
    endtask

    // driver: apply staged stimulus at negedge and push the expectation
    task automatic go(input string tag, input logic [2:0] m,
                      input logic al, input logic fl, input logic ve,
                      input logic en, input logic rf);
        exp_t e;
        @(negedge clk);
        start_req = s_start; start_private = s_priv; hash_done = s_hdone;
        suspend_req = s_susp; resume_req = s_res; exit_req = s_exit;
        resume_pc = s_rpc; acc_valid = s_val; acc_write = s_wr; acc_addr = s_addr;
        region_bound[1*AW +: AW] = s_bound1;
        e.tag = tag; e.m = m; e.o = {al, fl, ve, en, rf};
        exp_q.push_back(e);
        s_start = 0; s_priv = 0; s_hdone = 0; s_susp = 0; s_res = 0; s_exit = 0;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [4:0] got;
                e = exp_q.pop_front();
                got = {acc_allow, acc_fault, acc_need_verify, acc_need_encrypt, resume_fault};
                n_chk++;
                if (got !== e.o || mode !== e.m) begin
                    n_bad++;
                    $display("FAIL %s: mode=%0d outs=%b expected mode=%0d outs=%b",
                             e.tag, mode, got, e.m, e.o);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // outs order: allow fault verify encrypt resume_fault
        acc(0, 0, 0);            go("R1 reset mode std", 0, 0,0,0,0,0);
        acc(1, 0, 32'h8000);     go("R7 open in std", 0, 1,0,0,0,0);
        acc(1, 0, 32'h3000);     go("R8 protected in std", 0, 0,1,0,0,0);
        acc(1, 0, 32'h8000); s_start = 1;
                                 go("R2 start issued", 0, 1,0,0,0,0);
        acc(1, 0, 32'h1000);     go("R8 protected in hash", 1, 0,1,0,0,0);
                                 go("R2 hash holds", 1, 0,1,0,0,0);
        s_hdone = 1;             go("R2 hash done event", 1, 0,1,0,0,0);
        acc(1, 0, 32'h1000);     go("R10 tev static verified read", 2, 1,0,1,0,0);
        acc(1, 1, 32'h1000);     go("R9 tev static write", 2, 0,1,0,0,0);
        acc(1, 1, 32'h3FFF);     go("R10 tev dynamic write", 2, 1,0,1,0,0);
        acc(1, 0, 32'h2000);     go("R10 tev encrypted denied", 2, 0,1,0,0,0);
        acc(1, 0, 32'h8000); s_susp = 1;
                                 go("R3 suspend issued", 2, 1,0,0,0,0);
        acc(1, 0, 32'h3000);     go("R8 protected in suspended", 4, 0,1,0,0,0);
        acc(1, 0, 32'h8000); s_res = 1; s_rpc = 32'h200;
                                 go("R4 bad resume target", 4, 1,0,0,0,1);
                                 go("R4 stays suspended", 4, 1,0,0,0,0);
        s_res = 1; s_rpc = 32'h100;
                                 go("R3 good resume", 4, 1,0,0,0,0);
                                 go("R3 back in tev", 2, 1,0,0,0,0);
        s_res = 1; s_rpc = 32'h100;
                                 go("R4 resume outside suspended", 2, 1,0,0,0,1);
        s_susp = 1; s_exit = 1;  go("R5 exit with suspend", 2, 1,0,0,0,0);
        s_start = 1; s_priv = 1; go("R5 exit wins to std", 0, 1,0,0,0,0);
        s_hdone = 1;             go("R2 hashing for private", 1, 1,0,0,0,0);
        acc(1, 0, 32'h2000);     go("R11 private static encrypted read", 3, 1,0,1,1,0);
        acc(1, 1, 32'h4FFF);     go("R11 private dynamic encrypted write", 3, 1,0,1,1,0);
        acc(1, 1, 32'h3000);     go("R11 private dynamic verified write", 3, 1,0,1,0,0);
        acc(1, 1, 32'h2800);     go("R9 private static write", 3, 0,1,0,0,0);
        acc(1, 0, 32'h5000);     go("R6 bound is exclusive", 3, 1,0,0,0,0);
        acc(1, 0, 32'h0FFF);     go("R6 below first base", 3, 1,0,0,0,0);
        acc(1, 1, 32'h3400); s_bound1 = 32'h3800;
                                 go("R6 overlap lowest index wins", 3, 0,1,0,0,0);
        acc(0, 0, 32'h2000);     go("R12 idle access quiet", 3, 0,0,0,0,0);
        acc(1, 0, 32'h8000); s_susp = 1;
                                 go("R3 suspend from private", 3, 1,0,0,0,0);
        s_res = 1; s_rpc = 32'h100;
                                 go("R3 resume to private", 4, 1,0,0,0,0);
                                 go("R3 back in private", 3, 1,0,0,0,0);
        s_exit = 1;              go("R5 exit from private", 3, 1,0,0,0,0);
                                 go("R5 standard again", 0, 1,0,0,0,0);
        acc(1, 0, 32'h4000);     go("R8 protected after exit", 0, 0,1,0,0,0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule